// File: doc/BRIEF.md
# Indirect Configuration Window with Ticket Lock

This block is the device-side register window of a vendor-defined configuration capability. A host reaches it with single 32-bit dword reads and writes at fixed byte offsets from the capability base. Through five registers it can claim a hardware lock, pick one of several internal register domains, and move one word at a time between a data register and the selected domain through an address register that carries a completion flag.

Claiming the lock takes three steps. The host reads a ticket counter and writes the ticket it got into the lock register. It then reads the lock back and owns the window only if the lock now holds its own ticket. After that it selects a domain and checks that the status field reports it as supported. It then starts transfers. A transfer is a store when the address is written with the flag set; the block clears the flag once the word has reached the domain. It is a load when the address is written with the flag clear; the block sets the flag once the data register holds the word. Each domain is a small internal memory, and a transfer to one finishes a fixed, parameterised number of cycles after it starts.

Top module: `cfgGateway`

## Requirements
- R1: After reset the lock, selected domain, address, flag and data registers all read 0, the domain status reads 0, and the first read of the ticket counter returns 1.
- R2: Every read of the ticket register (offset 0x08) returns its current value and then advances it by one. When the increment would give zero, the counter goes to 1 instead, so it never reads 0.
- R3: A write of a nonzero value to the lock register (offset 0x0C) is stored only while the lock reads 0. It is ignored while the lock is held. A write of 0 always frees the lock.
- R4: A write to the domain register (offset 0x04) stores bits [15:0] as the domain id. Reads return the id in [15:0], the status in [31:29] and zeros elsewhere. The status is 1 when the id is 0x1, 0x6 or 0xA and 0 for any other id.
- R5: Writing the address register (offset 0x10) with bit 31 set, while a supported domain is selected and no transfer is pending, starts a store of the data register. Bit 31 then reads 1 for exactly LATENCY cycles and afterwards reads 0, with the word stored in the domain.
- R6: Writing the address register with bit 31 clear, while a supported domain is selected, starts a load. Bit 31 reads 0 for exactly LATENCY cycles and then reads 1, with the data register (offset 0x14) holding the stored word. The address field is bits [29:0], bit 30 reads 0, and the memory index is the low MEM_AW bits of the address.
- R7: Each supported domain has storage of its own. Equal addresses in different domains hold independent words.
- R8: While a transfer is pending, writes to the address register and to the data register are ignored. The flag keeps its pending value until completion.
- R9: When the selected domain is unsupported, a transfer completes at the next cycle. A store sets the flag to 0 and stores nothing. A load sets the flag to 1 and sets the data register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Dword write strobe for one cycle |
| regRdEn | input | 1 | Dword read strobe for one cycle |
| regOffset | input | 8 | Byte offset from the capability base |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle regRdEn is high, 0 otherwise |

## Verification
On every cycle the assertions check four things: the ticket counter is never zero, a nonzero lock write to a held lock leaves the lock unchanged, a pending transfer neither takes a new address nor moves its flag before it completes, and the domain memories never receive more than one strobe per cycle. Other behaviour shows up only in the bench's directed scenarios. These cover counter wrap-around and the full lock claim and release. They also count cycles to show the exact completion latency, check that domains hold separate data, and check the immediate zero-result completion when an unsupported domain is selected.

// File: rtl/cfgGatewayPkg.sv
package cfgGatewayPkg;

  localparam int NumDomains = 3;
  localparam logic [15:0] DomainIds [NumDomains] = '{16'h0001, 16'h0006, 16'h000A};
  localparam int DomSelW = (NumDomains > 1) ? $clog2(NumDomains) : 1;

  localparam logic [7:0] OffSpace  = 8'h04;
  localparam logic [7:0] OffTicket = 8'h08;
  localparam logic [7:0] OffLock   = 8'h0C;
  localparam logic [7:0] OffAddr   = 8'h10;
  localparam logic [7:0] OffData   = 8'h14;

  localparam logic [2:0] StatusOk  = 3'd1;
  localparam logic [2:0] StatusBad = 3'd0;

  typedef struct packed {
    logic               dataLoad;
    logic               memWr;
    logic               memRd;
    logic               dataZero;
    logic [DomSelW-1:0] domSel;
  } gwStrobe_t;

endpackage

// File: rtl/cfgGatewayCtrl.sv
module cfgGatewayCtrl
  import cfgGatewayPkg::*;
#(
  parameter int COUNTER_W = 32,
  parameter int LATENCY   = 4,
  parameter int MEM_AW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regOffset,
  input  logic [31:0]       regWrData,
  input  logic [31:0]       dataRegIn,
  output logic [31:0]       regRdData,
  output gwStrobe_t         strobe,
  output logic [MEM_AW-1:0] memAddr
);

  localparam int WaitW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [WaitW-1:0] WaitLoad = WaitW'(LATENCY - 1);

  logic spaceWr, ticketRd, lockWr, addrWr, dataWr;
  assign spaceWr  = regWrEn && (regOffset == OffSpace);
  assign ticketRd = regRdEn && (regOffset == OffTicket);
  assign lockWr   = regWrEn && (regOffset == OffLock);
  assign addrWr   = regWrEn && (regOffset == OffAddr);
  assign dataWr   = regWrEn && (regOffset == OffData);

  // ticket counter
  logic [COUNTER_W-1:0] ticketReg, ticketInc, ticketNext;
  assign ticketInc  = ticketReg + 1'b1;
  assign ticketNext = (ticketInc == '0) ? COUNTER_W'(1) : ticketInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ticketReg <= COUNTER_W'(1);
    else if (ticketRd) ticketReg <= ticketNext;
  end

  // lock register
  logic [31:0] lockReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockReg <= '0;
    else if (lockWr) begin
      if (regWrData == '0)    lockReg <= '0;
      else if (lockReg == '0) lockReg <= regWrData;
    end
  end

  // domain select
  logic [15:0]        spaceId;
  logic               spaceOk;
  logic [DomSelW-1:0] spaceIdx;
  logic               newHit;
  logic [DomSelW-1:0] newIdx;

  always_comb begin
    newHit = 1'b0;
    newIdx = '0;
    for (int i = 0; i < NumDomains; i++) begin
      if (regWrData[15:0] == DomainIds[i]) begin
        newHit = 1'b1;
        newIdx = DomSelW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spaceId  <= '0;
      spaceOk  <= 1'b0;
      spaceIdx <= '0;
    end else if (spaceWr) begin
      spaceId  <= regWrData[15:0];
      spaceOk  <= newHit;
      spaceIdx <= newIdx;
    end
  end

  // transfer sequencer
  logic [29:0]        addrReg;
  logic               flagReg;
  logic               busy;
  logic               opIsWrite;
  logic [DomSelW-1:0] opDom;
  logic [WaitW-1:0]   waitCnt;
  logic               doneNow;
  logic               startOk;
  logic               startBad;

  assign doneNow  = busy && (waitCnt == '0);
  assign startOk  = addrWr && !busy && spaceOk;
  assign startBad = addrWr && !busy && !spaceOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      flagReg   <= 1'b0;
      busy      <= 1'b0;
      opIsWrite <= 1'b0;
      opDom     <= '0;
      waitCnt   <= '0;
    end else if (busy) begin
      if (waitCnt == '0) begin
        busy    <= 1'b0;
        flagReg <= !opIsWrite;
      end else begin
        waitCnt <= waitCnt - 1'b1;
      end
    end else if (startOk) begin
      addrReg   <= regWrData[29:0];
      flagReg   <= regWrData[31];
      opIsWrite <= regWrData[31];
      opDom     <= spaceIdx;
      waitCnt   <= WaitLoad;
      busy      <= 1'b1;
    end else if (startBad) begin
      addrReg <= regWrData[29:0];
      flagReg <= !regWrData[31];
    end
  end

  always_comb begin
    strobe.dataLoad = dataWr && !busy;
    strobe.memWr    = doneNow && opIsWrite;
    strobe.memRd    = doneNow && !opIsWrite;
    strobe.dataZero = startBad && !regWrData[31];
    strobe.domSel   = opDom;
  end
  assign memAddr = addrReg[MEM_AW-1:0];

  // read mux
  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regOffset)
        OffSpace:  regRdData = {(spaceOk ? StatusOk : StatusBad), 13'b0, spaceId};
        OffTicket: regRdData = 32'(ticketReg);
        OffLock:   regRdData = lockReg;
        OffAddr:   regRdData = {flagReg, 1'b0, addrReg};
        OffData:   regRdData = dataRegIn;
        default:   regRdData = '0;
      endcase
    end
  end

  // R2
  ticket_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ticketReg != '0);

  // R3
  lock_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockWr && regWrData != '0 && lockReg != '0) |=> $stable(lockReg));

  // R8
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && addrWr) |=> $stable(addrReg));

  // R8
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneNow) |=> $stable(flagReg));

endmodule

// File: rtl/cfgGatewayData.sv
module cfgGatewayData
  import cfgGatewayPkg::*;
#(
  parameter int MEM_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  gwStrobe_t         strobe,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       dataReg
);

  localparam int MemDepth = 1 << MEM_AW;

  logic [31:0] rdWord [NumDomains];

  for (genvar d = 0; d < NumDomains; d++) begin : gDom
    logic [31:0] mem [MemDepth];
    always_ff @(posedge clk) begin
      if (strobe.memWr && strobe.domSel == DomSelW'(d)) mem[memAddr] <= dataReg;
    end
    assign rdWord[d] = mem[memAddr];
  end

  logic [31:0] selWord;
  always_comb begin
    selWord = '0;
    for (int i = 0; i < NumDomains; i++) begin
      if (strobe.domSel == DomSelW'(i)) selWord = rdWord[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataReg <= '0;
    else if (strobe.dataZero) dataReg <= '0;
    else if (strobe.memRd)    dataReg <= selWord;
    else if (strobe.dataLoad) dataReg <= regWrData;
  end

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.dataLoad, strobe.memWr, strobe.memRd, strobe.dataZero}));

  // R7
  dom_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.memWr || strobe.memRd) |-> (int'(strobe.domSel) < NumDomains));

endmodule

// File: rtl/cfgGateway.sv
module cfgGateway
  import cfgGatewayPkg::*;
#(
  parameter int COUNTER_W = 32,
  parameter int LATENCY   = 4,
  parameter int MEM_AW    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regOffset,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);

  gwStrobe_t         strobe;
  logic [MEM_AW-1:0] memAddr;
  logic [31:0]       dataReg;

  cfgGatewayCtrl #(
    .COUNTER_W(COUNTER_W),
    .LATENCY  (LATENCY),
    .MEM_AW   (MEM_AW)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regOffset(regOffset),
    .regWrData(regWrData),
    .dataRegIn(dataReg),
    .regRdData(regRdData),
    .strobe   (strobe),
    .memAddr  (memAddr)
  );

  cfgGatewayData #(
    .MEM_AW(MEM_AW)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .memAddr  (memAddr),
    .regWrData(regWrData),
    .dataReg  (dataReg)
  );

endmodule

// File: tb/test_cfgGateway.sv
module test_cfgGateway;

  localparam int PERIOD  = 10;
  localparam int CW      = 8;
  localparam int LAT     = 4;

  localparam logic [7:0] SPACE = 8'h04, TICKET = 8'h08, LOCK = 8'h0C, ADDR = 8'h10, DATA = 8'h14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regOffset = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int checks = 0;
  int fails  = 0;
  int expTicket = 1;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cfgGateway #(.COUNTER_W(CW), .LATENCY(LAT), .MEM_AW(4)) i_cfgGateway (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regOffset(regOffset), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regOffset = off; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic busRd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regOffset = off;
    #(PERIOD/4);
    d = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic readTicket(output logic [31:0] d);
    busRd(TICKET, d);
    expTicket = (expTicket == (1 << CW) - 1) ? 1 : expTicket + 1;
  endtask

  task automatic pollFlag(input logic want, output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      busRd(ADDR, v);
      if (v[31] == want) break;
      n++;
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRd(SPACE, v);  chk("R1 space", v, 32'h0);
    busRd(LOCK, v);   chk("R1 lock", v, 32'h0);
    busRd(ADDR, v);   chk("R1 addr", v, 32'h0);
    busRd(DATA, v);   chk("R1 data", v, 32'h0);
    chk("R1 ticket start", 32'(expTicket), 32'd1);
    readTicket(v);    chk("R1 first ticket", v, 32'd1);
  endtask

  task automatic testTicket();
    logic [31:0] v;
    int exp;
    for (int i = 0; i < 3; i++) begin
      exp = expTicket;
      readTicket(v);
      chk("R2 increment", v, 32'(exp));
    end
    while (expTicket != (1 << CW) - 1) readTicket(v);
    readTicket(v); chk("R2 top value", v, 32'((1 << CW) - 1));
    readTicket(v); chk("R2 wrap skips zero", v, 32'd1);
  endtask

  task automatic testLock();
    logic [31:0] v, t;
    busRd(LOCK, v); chk("R3 free", v, 32'h0);
    readTicket(t);
    busWr(LOCK, t);
    busRd(LOCK, v); chk("R3 claimed", v, t);
    busWr(LOCK, 32'h55);
    busRd(LOCK, v); chk("R3 held ignores write", v, t);
    busWr(LOCK, 32'h0);
    busRd(LOCK, v); chk("R3 released", v, 32'h0);
  endtask

  task automatic testSpace();
    logic [31:0] v;
    busWr(SPACE, 32'h1);  busRd(SPACE, v); chk("R4 id 0x1", v, 32'h2000_0001);
    busWr(SPACE, 32'h6);  busRd(SPACE, v); chk("R4 id 0x6", v, 32'h2000_0006);
    busWr(SPACE, 32'hA);  busRd(SPACE, v); chk("R4 id 0xA", v, 32'h2000_000A);
    busWr(SPACE, 32'h2);  busRd(SPACE, v); chk("R4 id 0x2 bad", v, 32'h0000_0002);
    busWr(SPACE, 32'hFFFF_0003); busRd(SPACE, v); chk("R4 upper ignored", v, 32'h0000_0003);
  endtask

  task automatic storeWord(input logic [15:0] dom, input logic [29:0] a, input logic [31:0] d);
    int n;
    busWr(SPACE, 32'(dom));
    busWr(DATA, d);
    busWr(ADDR, {2'b10, a});
    pollFlag(1'b0, n);
    chk("R5 store latency", 32'(n), 32'(LAT));
  endtask

  task automatic loadWord(input logic [15:0] dom, input logic [29:0] a, input logic [31:0] exp);
    int n;
    logic [31:0] v;
    busWr(SPACE, 32'(dom));
    busWr(ADDR, {2'b00, a});
    pollFlag(1'b1, n);
    chk("R6 load latency", 32'(n), 32'(LAT));
    busRd(ADDR, v); chk("R6 addr readback", v, {2'b10, a});
    busRd(DATA, v); chk("R6 load data", v, exp);
  endtask

  task automatic testDomains();
    storeWord(16'h1, 30'd3, 32'hA1A1_0001);
    storeWord(16'h6, 30'd3, 32'hB6B6_0006);
    storeWord(16'hA, 30'd3, 32'hCACA_000A);
    loadWord(16'h1, 30'd3, 32'hA1A1_0001);   // R7
    loadWord(16'h6, 30'd3, 32'hB6B6_0006);   // R7
    loadWord(16'hA, 30'd3, 32'hCACA_000A);   // R7
    storeWord(16'h6, 30'h1000_0012, 32'h1234_5678);
    loadWord(16'h6, 30'd2, 32'h1234_5678);   // R6 low index bits
  endtask

  task automatic testBusy();
    logic [31:0] v;
    int n;
    busWr(SPACE, 32'hA);
    busWr(DATA, 32'h1111_1111);
    busWr(ADDR, {2'b10, 30'd5});
    busRd(ADDR, v); chk("R8 flag pending", v, {2'b10, 30'd5});
    busWr(ADDR, {2'b10, 30'd7});
    busWr(DATA, 32'h2222_2222);
    pollFlag(1'b0, n);
    busRd(ADDR, v); chk("R8 addr write ignored", v, {2'b00, 30'd5});
    busRd(DATA, v); chk("R8 data write ignored", v, 32'h1111_1111);
    loadWord(16'hA, 30'd5, 32'h1111_1111);
  endtask

  task automatic testUnsupported();
    logic [31:0] v;
    storeWord(16'h1, 30'd9, 32'h0BAD_0009);
    busWr(SPACE, 32'h2);
    busWr(DATA, 32'hDEAD_BEEF);
    busWr(ADDR, {2'b10, 30'd9});
    busRd(ADDR, v); chk("R9 store done at once", v, {2'b00, 30'd9});
    busWr(ADDR, {2'b00, 30'd9});
    busRd(ADDR, v); chk("R9 load done at once", v, {2'b10, 30'd9});
    busRd(DATA, v); chk("R9 load returns zero", v, 32'h0);
    loadWord(16'h1, 30'd9, 32'h0BAD_0009);   // R9 nothing stored
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testTicket();
    testLock();
    testSpace();
    testDomains();
    testBusy();
    testUnsupported();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule